// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind the serial command decoder of a small serial EEPROM. Once software has armed the write-enable latch, the decoder hands over a start address and then each received data byte as single-cycle strobes. The block gathers up to one page of bytes in a local buffer. The load offset advances inside the page and wraps at its end, so a later byte can replace an earlier one. When chip select returns high, the block starts a timed internal program cycle. During that cycle it writes every buffered location to the array through a simple write port, drives a busy flag, and finally clears the write-enable latch.

The same sequencer also commits the two writable status bits, which are block-protect controls. It applies the write-protect input as well. Protect held low blocks any new command. Protect falling while a command is still open cancels that command. Once a program cycle is running, protect has no effect on it. The real programming time is modelled by a cycle counter whose length is a parameter.

Top module: `pgwr_seq`

## Requirements
- R1: `wel` is 0 after reset and is set by `wren_stb` while idle. An address or status strobe opens a command only when `wel` is 1 and `wp_n` is 1. Otherwise the strobe has no effect and no program cycle follows.
- R2: The first data byte goes to the start address. Each later byte goes to the next offset in the low log2(PAGE_BYTES) address bits. The page bits (upper address bits) never change.
- R3: Loading past the last offset of the page wraps to offset 0. A later byte to an already loaded offset replaces the earlier byte, and that location is written to the array only once.
- R4: `busy` rises in the cycle after `cs_rise` is sampled with an open array command that holds at least one byte, or with an open status command. It stays high for exactly PROG_CYC cycles.
- R5: `wel` is 0 from the cycle in which `busy` falls.
- R6: During the first PAGE_BYTES cycles of `busy`, the block pulses `arr_we` once for each loaded offset, in ascending offset order, with the page's address and the buffered byte. Offsets that were not loaded are never written.
- R7: `wp_n` low while a command is open cancels it. A following `cs_rise` starts no cycle, nothing is written, and `wel` stays 1.
- R8: `wp_n` going low while `busy` is high does not shorten the cycle and does not stop any array write.
- R9: `cs_rise` on an array command with no complete data byte starts no cycle and leaves `wel` at 1.
- R10: A status command stores `sr_in[2]` into `prot[0]` and `sr_in[3]` into `prot[1]` in the cycle `busy` falls. All other `sr_in` bits are ignored, and `prot` changes at no other time.
- R11: While `busy` is high, every strobe is ignored: `wren_stb`, `addr_stb`, `byte_stb`, `sr_stb` and `cs_rise`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_stb | input | 1 | Set the write-enable latch |
| addr_stb | input | 1 | Start address of an array write is valid |
| addr_in | input | ADDR_W | Start address |
| byte_stb | input | 1 | One complete data byte received |
| byte_in | input | 8 | Data byte |
| sr_stb | input | 1 | Status data byte of a status write received |
| sr_in | input | 8 | Status data byte |
| cs_rise | input | 1 | Chip select has gone high (command end) |
| wp_n | input | 1 | Write protect, active low |
| busy | output | 1 | Internal program cycle running |
| wel | output | 1 | Write-enable latch |
| prot | output | 2 | Block-protect status bits |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with PROG_CYC = 24, a 9-bit address and a 16-byte page. The short cycle lets it count the busy interval exactly for every write. The 9-bit address puts the top page and the last offset of a page within reach, so wrap at offset 15 and a 20-byte overrun with overwrite are both exercised. A table of start address, byte count and seed drives the array writes. Directed sequences then cover protect cancellation, protect during busy, zero-byte commands, status commits and strobes during busy.

// File: rtl/pgwr_pkg.sv
`timescale 1ns/1ps
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARR  = 2'd1,
    ST_STAT = 2'd2,
    ST_PROG = 2'd3
  } pg_state_e;

  typedef enum logic {
    JOB_ARR  = 1'b0,
    JOB_STAT = 1'b1
  } pg_job_e;
endpackage

// File: rtl/pgwr_buf.sv
`timescale 1ns/1ps
// One page of data slots, each with a loaded flag.
module pgwr_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_ofs,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [OFS_W-1:0]  rd_ofs,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  logic [DATA_W-1:0]     data_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;
  logic [PAGE_BYTES-1:0] hit;
  logic [PAGE_BYTES-1:0] valid_d;

  genvar g;
  generate
    for (g = 0; g < PAGE_BYTES; g++) begin : g_slot
      assign hit[g] = wr_en && (wr_ofs == OFS_W'(g));
    end
  endgenerate

  // Data slots carry no reset; they are only read when flagged valid.
  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (hit[i]) data_q[i] <= wr_data;
    end
  end

  always_comb begin
    if (clr) valid_d = '0;
    else     valid_d = valid_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  assign rd_data   = data_q[rd_ofs];
  assign rd_valid  = valid_q[rd_ofs];
  assign any_valid = |valid_q;
endmodule

// File: rtl/pgwr_timer.sv
`timescale 1ns/1ps
// Program-cycle counter: runs CYC cycles after start.
module pgwr_timer #(
  parameter int CYC    = 64,
  localparam int CNT_W = $clog2(CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] END_VAL = CNT_W'(CYC - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (start) begin
      run_d  = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (run_q) begin
      cnt_en = 1'b1;
      if (cnt_q == END_VAL) run_d = 1'b0;
      else                  cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt  = cnt_q;
  assign last = run_q && (cnt_q == END_VAL);
endmodule

// File: rtl/pgwr_ctrl.sv
`timescale 1ns/1ps
// Command sequencer: write latch, load pointer, protect, status bits.
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_stb,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic              sr_stb,
  input  logic [1:0]        sr_bits,
  input  logic              cs_rise,
  input  logic              wp_n,
  input  logic              any_valid,
  input  logic              tmr_last,
  output pg_state_e         state,
  output pg_job_e           job,
  output logic [PG_W-1:0]   page,
  output logic              wel,
  output logic [1:0]        prot,
  output logic              buf_clr,
  output logic              buf_wr,
  output logic [OFS_W-1:0]  buf_ofs,
  output logic              tmr_start
);
  pg_state_e        st_q, st_d;
  pg_job_e          job_q, job_d;
  logic [PG_W-1:0]  page_q, page_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             wel_q, wel_d;
  logic [1:0]       stage_q, stage_d;
  logic [1:0]       prot_q, prot_d;
  logic             cmd_ok;

  assign cmd_ok = wel_q && wp_n;

  always_comb begin
    st_d      = st_q;
    job_d     = job_q;
    page_d    = page_q;
    ofs_d     = ofs_q;
    wel_d     = wel_q;
    stage_d   = stage_q;
    prot_d    = prot_q;
    buf_clr   = 1'b0;
    buf_wr    = 1'b0;
    tmr_start = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (wren_stb) wel_d = 1'b1;
        if (addr_stb && cmd_ok) begin
          st_d    = ST_ARR;
          job_d   = JOB_ARR;
          page_d  = addr_in[ADDR_W-1:OFS_W];
          ofs_d   = addr_in[OFS_W-1:0];
          buf_clr = 1'b1;
        end else if (sr_stb && cmd_ok) begin
          st_d    = ST_STAT;
          job_d   = JOB_STAT;
          stage_d = sr_bits;
        end
      end
      ST_ARR: begin
        if (!wp_n) begin
          st_d    = ST_IDLE;
          buf_clr = 1'b1;
        end else if (cs_rise) begin
          if (any_valid) begin
            st_d      = ST_PROG;
            tmr_start = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else if (byte_stb) begin
          buf_wr = 1'b1;
          ofs_d  = ofs_q + OFS_W'(1);
        end
      end
      ST_STAT: begin
        if (!wp_n) begin
          st_d = ST_IDLE;
        end else if (cs_rise) begin
          st_d      = ST_PROG;
          tmr_start = 1'b1;
        end
      end
      ST_PROG: begin
        if (tmr_last) begin
          st_d    = ST_IDLE;
          wel_d   = 1'b0;
          buf_clr = 1'b1;
          if (job_q == JOB_STAT) prot_d = stage_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      job_q   <= JOB_ARR;
      page_q  <= '0;
      ofs_q   <= '0;
      wel_q   <= 1'b0;
      stage_q <= '0;
      prot_q  <= '0;
    end else begin
      st_q    <= st_d;
      job_q   <= job_d;
      page_q  <= page_d;
      ofs_q   <= ofs_d;
      wel_q   <= wel_d;
      stage_q <= stage_d;
      prot_q  <= prot_d;
    end
  end

  assign state   = st_q;
  assign job     = job_q;
  assign page    = page_q;
  assign wel     = wel_q;
  assign prot    = prot_q;
  assign buf_ofs = ofs_q;
endmodule

// File: rtl/pgwr_seq.sv
`timescale 1ns/1ps
// Top: page write buffer and program sequencer.
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int PROG_CYC   = 1000   // must be >= PAGE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_stb,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_stb,
  input  logic [7:0]        byte_in,
  input  logic              sr_stb,
  input  logic [7:0]        sr_in,
  input  logic              cs_rise,
  input  logic              wp_n,
  output logic              busy,
  output logic              wel,
  output logic [1:0]        prot,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int CNT_W = $clog2(PROG_CYC + 1);
  localparam logic [CNT_W-1:0] SWEEP_END = CNT_W'(PAGE_BYTES);

  // Asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic unused_sr_bits;
  assign unused_sr_bits = ^{sr_in[7:4], sr_in[1:0]};

  pg_state_e        state;
  pg_job_e          job;
  logic [PG_W-1:0]  page;
  logic             buf_clr, buf_wr, tmr_start, tmr_last, any_valid;
  logic [OFS_W-1:0] buf_ofs, rd_ofs;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic [CNT_W-1:0] tcnt;

  pgwr_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wren_stb  (wren_stb),
    .addr_stb  (addr_stb),
    .addr_in   (addr_in),
    .byte_stb  (byte_stb),
    .sr_stb    (sr_stb),
    .sr_bits   (sr_in[3:2]),
    .cs_rise   (cs_rise),
    .wp_n      (wp_n),
    .any_valid (any_valid),
    .tmr_last  (tmr_last),
    .state     (state),
    .job       (job),
    .page      (page),
    .wel       (wel),
    .prot      (prot),
    .buf_clr   (buf_clr),
    .buf_wr    (buf_wr),
    .buf_ofs   (buf_ofs),
    .tmr_start (tmr_start)
  );

  pgwr_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(8)) u_buf (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clr       (buf_clr),
    .wr_en     (buf_wr),
    .wr_ofs    (buf_ofs),
    .wr_data   (byte_in),
    .rd_ofs    (rd_ofs),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .any_valid (any_valid)
  );

  pgwr_timer #(.CYC(PROG_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (tmr_start),
    .cnt   (tcnt),
    .last  (tmr_last)
  );

  // The first PAGE_BYTES cycles of the program cycle sweep the page.
  assign busy      = (state == ST_PROG);
  assign rd_ofs    = tcnt[OFS_W-1:0];
  assign arr_we    = busy && (job == JOB_ARR) && (tcnt < SWEEP_END) && rd_valid;
  assign arr_addr  = {page, rd_ofs};
  assign arr_wdata = rd_data;
endmodule

// File: rtl/pgwr_chk.sv
`timescale 1ns/1ps
module pgwr_chk #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16,
  parameter int PROG_CYC   = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wren_stb,
  input logic              cs_rise,
  input logic              wp_n,
  input logic              busy,
  input logic              wel,
  input logic [1:0]        prot,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr
);
  localparam int OFS_W = $clog2(PAGE_BYTES);

  int blen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen_q <= 0;
    else if (busy) blen_q <= blen_q + 1;
    else           blen_q <= 0;
  end

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen_q == PROG_CYC));
  p_busy_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  p_wel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      (arr_addr[ADDR_W-1:OFS_W] == $past(arr_addr[ADDR_W-1:OFS_W])));
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wp_n) |=> !busy);
  p_prot_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot) |-> $fell(busy));
  p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wren_stb) |=> !$rose(wel));
endmodule

bind pgwr_seq pgwr_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .cs_rise(cs_rise),
  .wp_n(wp_n), .busy(busy), .wel(wel), .prot(prot),
  .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/sim_pgwr_seq.sv
`timescale 1ns/1ps
module sim_pgwr_seq;
  localparam int AW  = 9;
  localparam int PB  = 16;
  localparam int CYC = 24;

  logic          clk, rst_n;
  logic          wren_stb, addr_stb, byte_stb, sr_stb, cs_rise, wp_n;
  logic [AW-1:0] addr_in;
  logic [7:0]    byte_in, sr_in;
  logic          busy, wel, arr_we;
  logic [1:0]    prot;
  logic [AW-1:0] arr_addr;
  logic [7:0]    arr_wdata;

  pgwr_seq #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYC(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .addr_stb(addr_stb),
    .addr_in(addr_in), .byte_stb(byte_stb), .byte_in(byte_in),
    .sr_stb(sr_stb), .sr_in(sr_in), .cs_rise(cs_rise), .wp_n(wp_n),
    .busy(busy), .wel(wel), .prot(prot), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int wr_cnt = 0;
  logic [7:0] mem [1 << AW];

  always @(posedge clk) begin
    if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic p_wren();
    @(negedge clk) wren_stb = 1'b1;
    @(negedge clk) wren_stb = 1'b0;
  endtask
  task automatic p_addr(input logic [AW-1:0] a);
    @(negedge clk) begin addr_in = a; addr_stb = 1'b1; end
    @(negedge clk) addr_stb = 1'b0;
  endtask
  task automatic p_byte(input logic [7:0] d);
    @(negedge clk) begin byte_in = d; byte_stb = 1'b1; end
    @(negedge clk) byte_stb = 1'b0;
  endtask
  task automatic p_sr(input logic [7:0] d);
    @(negedge clk) begin sr_in = d; sr_stb = 1'b1; end
    @(negedge clk) sr_stb = 1'b0;
  endtask
  task automatic p_cs();
    @(negedge clk) cs_rise = 1'b1;
    @(negedge clk) cs_rise = 1'b0;
  endtask
  task automatic wait_prog(output int n);
    n = 0;
    while (busy && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // {start address, byte count, first data value}
  localparam logic [21:0] VEC [6] = '{
    {9'h000, 5'd1,  8'h11},
    {9'h023, 5'd3,  8'h40},
    {9'h1F0, 5'd16, 8'h80},
    {9'h0AE, 5'd20, 8'hC0},
    {9'h0FF, 5'd2,  8'h5A},
    {9'h135, 5'd4,  8'h21}
  };

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog R4 act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'h00;
    rst_n = 1'b0; wren_stb = 0; addr_stb = 0; byte_stb = 0; sr_stb = 0;
    cs_rise = 0; wp_n = 1'b1; addr_in = '0; byte_in = '0; sr_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    chk("R1 reset wel", wel, 0);
    chk("R4 reset busy", busy, 0);
    chk("R6 reset arr_we", arr_we, 0);
    chk("R10 reset prot", prot, 0);

    // R1: no command without the latch
    wr_cnt = 0;
    p_addr(9'h010); p_byte(8'hAA); p_cs();
    chk("R1 no latch busy", busy, 0);
    repeat (2) @(negedge clk);
    chk("R1 no latch writes", wr_cnt, 0);

    // Table walk
    for (int v = 0; v < 6; v++) begin
      logic [AW-1:0] a;
      int cnt;
      logic [7:0] seed;
      logic [7:0] exp [PB];
      logic       ev [PB];
      int nv;
      string tg;
      a = VEC[v][21:13]; cnt = int'(VEC[v][12:8]); seed = VEC[v][7:0];
      tg = (cnt > PB) ? "R3" : "R2";
      for (int k = 0; k < PB; k++) ev[k] = 1'b0;
      for (int i = 0; i < cnt; i++) begin
        int loc;
        loc = (int'(a[3:0]) + i) % PB;
        exp[loc] = seed + 8'(i);
        ev[loc] = 1'b1;
      end
      wr_cnt = 0;
      p_wren();
      chk("R1 latch set", wel, 1);
      p_addr(a);
      for (int i = 0; i < cnt; i++) p_byte(seed + 8'(i));
      p_cs();
      chk("R4 busy after cs", busy, 1);
      wait_prog(n);
      chk("R4 busy length", n, CYC);
      chk("R5 latch cleared", wel, 0);
      nv = 0;
      for (int k = 0; k < PB; k++) begin
        if (ev[k]) begin
          nv++;
          chk(tg, mem[{a[AW-1:4], 4'(k)}], exp[k]);
        end
      end
      chk("R6 write count", wr_cnt, nv);
    end

    // R10: status commit
    p_wren(); p_sr(8'hFF); p_cs(); wait_prog(n);
    chk("R10 prot all", prot, 2'b11);
    chk("R5 latch after status", wel, 0);
    p_wren(); p_sr(8'hF4); p_cs(); wait_prog(n);
    chk("R10 prot bit2 only", prot, 2'b01);
    // Protect low: status write inhibited
    wp_n = 1'b0;
    p_wren(); p_sr(8'h08); p_cs();
    chk("R10 protected no busy", busy, 0);
    repeat (CYC + 2) @(negedge clk);
    chk("R10 protected prot", prot, 2'b01);
    wp_n = 1'b1;

    // R7: protect falls while command open
    wr_cnt = 0;
    p_wren(); p_addr(9'h050); p_byte(8'h01); p_byte(8'h02);
    @(negedge clk) wp_n = 1'b0;
    @(negedge clk) wp_n = 1'b1;
    p_cs();
    chk("R7 cancel busy", busy, 0);
    repeat (CYC + 2) @(negedge clk);
    chk("R7 cancel writes", wr_cnt, 0);
    chk("R7 latch kept", wel, 1);

    // R9: command ends before any byte
    p_addr(9'h060); p_cs();
    chk("R9 no busy", busy, 0);
    chk("R9 latch kept", wel, 1);

    // R8: protect falls during busy
    wr_cnt = 0;
    p_addr(9'h070); p_byte(8'h77); p_cs();
    @(negedge clk) wp_n = 1'b0;
    wait_prog(n);
    chk("R8 busy length", n, CYC - 1);
    chk("R8 write done", wr_cnt, 1);
    chk("R8 data", mem[9'h070], 8'h77);
    wp_n = 1'b1;

    // R11: strobes during busy
    wr_cnt = 0;
    p_wren(); p_addr(9'h080); p_byte(8'h33); p_cs();
    p_wren(); p_addr(9'h090); p_byte(8'h44); p_sr(8'h00);
    wait_prog(n);
    chk("R11 latch not set", wel, 0);
    chk("R11 prot kept", prot, 2'b01);
    p_cs();
    chk("R11 no second cycle", busy, 0);
    chk("R11 single write", wr_cnt, 1);
    chk("R11 no stray data", mem[9'h090], 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule